// File: doc/BRIEF.md
# AES-128 Iterative Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key per request. A request carries the key, the data block and a direction bit; the engine first expands the key into a bank of eleven round keys, then runs one cipher round per clock cycle through either a forward or an inverse round datapath. Both datapaths share the single round-key bank and the single sequencer. The forward path builds its column mix from xtime and XOR only. The inverse path does the same with repeated doubling. Byte substitution is a lookup table that is computed at elaboration, and row shifting is a fixed byte rewiring.

The input side is a valid/ready pair. A request is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the engine is idle, so an upstream source sees back-pressure for the whole operation. The output side is also a valid/ready pair. `out_valid` rises when the result is ready and stays high, with `out_data` frozen, until the sink takes it by raising `out_ready`. The engine accepts nothing new until the result has been taken. Blocks are byte-serialised big-end first: byte 0 of the cipher state sits in bits [127:120], and bytes run down the columns (bytes 0 to 3 form column 0).

Top module: `aes_core`

## Requirements
- R1: `in_ready` is high only while idle; a request is taken when `in_valid` and `in_ready` are both high, and `in_valid`, `in_decrypt`, `in_key` and `in_data` have no effect while the engine is busy or holding a result.
- R2: `out_valid` rises exactly 21 clock cycles after the cycle in which a request was taken.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is stable. The cycle after `out_ready` is seen high, `out_valid` is low and `in_ready` is high.
- R4: With `in_decrypt` = 0, the engine encrypts. Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a, byte 0 being bits [127:120].
- R5: With `in_decrypt` = 1, the engine decrypts. The same key with 69c4e0d86a7b0430d8cdb78070b4c55a gives 00112233445566778899aabbccddeeff.
- R6: For any key and block, the encryption result equals the standard AES-128 cipher output, and decrypting that result under the same key returns the original block.
- R7: After reset, `in_ready` is 1 and `out_valid` is 0.
- R8: Each request uses its own key. A key that differs from the previous request's key is fully re-expanded, with no trace of the earlier schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle and able to take a request |
| in_decrypt | input | 1 | Direction: 0 encrypt, 1 decrypt |
| in_key | input | 128 | Cipher key, byte 0 in [127:120] |
| in_data | input | 128 | Plaintext or ciphertext block |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result |
| out_data | output | 128 | Result block |

## Verification
The assertions treat the request fields as meaningful only on the accepting cycle. They place no limit on `out_ready`, which may be low for any number of cycles. The stimulus keeps `in_valid` high with inverted garbage fields during the whole busy period of some operations, to show those fields are ignored. It also holds `out_ready` low for zero to three cycles before releasing a result. Random keys and blocks come from a seeded generator, and a bench model of the cipher predicts every encryption. Each decryption is fed a ciphertext that the model produced, so its expected value is the known plaintext.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BLK_BYTES  = 16;
  localparam int COL_BYTES  = 4;
  localparam int NUM_COLS   = BLK_BYTES / COL_BYTES;
  localparam int BLK_BITS   = 8 * BLK_BYTES;
  localparam int COL_BITS   = 8 * COL_BYTES;
  localparam int NUM_ROUNDS = 10;
  localparam int IDX_W      = $clog2(NUM_ROUNDS + 2);
  localparam int LATENCY    = 2 * NUM_ROUNDS + 1;

  typedef logic [7:0]          byte_t;
  typedef logic [BLK_BITS-1:0] blk_t;
  typedef logic [COL_BITS-1:0] col_t;
  typedef logic [255:0][7:0]   tbl_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_EXPAND, PH_WHITEN, PH_ROUND, PH_OUT
  } phase_t;

  function automatic byte_t xt(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(byte_t a, byte_t b);
    byte_t acc = 8'h00;
    byte_t run = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ run;
      run = xt(run);
    end
    return acc;
  endfunction

  // a^254 by square-and-multiply; maps 0 to 0
  function automatic byte_t ginv(byte_t a);
    byte_t r = 8'h01;
    byte_t s = a;
    for (int k = 1; k < 8; k++) begin
      s = gmul(s, s);
      r = gmul(r, s);
    end
    return r;
  endfunction

  function automatic byte_t affine(byte_t b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic tbl_t fwd_tbl();
    tbl_t t;
    for (int i = 0; i < 256; i++) t[i] = affine(ginv(byte_t'(i)));
    return t;
  endfunction

  function automatic tbl_t inv_tbl();
    tbl_t f = fwd_tbl();
    tbl_t t;
    for (int i = 0; i < 256; i++) t[f[i]] = byte_t'(i);
    return t;
  endfunction

  // row r of column c moves by r positions; left when forward, right when inverse
  function automatic blk_t shift_rows(blk_t s, logic inverse);
    blk_t o;
    for (int c = 0; c < NUM_COLS; c++) begin
      for (int r = 0; r < COL_BYTES; r++) begin
        int src;
        src = inverse ? (c + NUM_COLS - r) % NUM_COLS : (c + r) % NUM_COLS;
        o[BLK_BITS-1-8*(COL_BYTES*c+r) -: 8] = s[BLK_BITS-1-8*(COL_BYTES*src+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic col_t mix_col(col_t x);
    byte_t a0 = x[31:24];
    byte_t a1 = x[23:16];
    byte_t a2 = x[15:8];
    byte_t a3 = x[7:0];
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  // constants 9, 11, 13, 14 from doublings of a
  function automatic byte_t mul_k(byte_t a, int k);
    byte_t d2 = xt(a);
    byte_t d4 = xt(d2);
    byte_t d8 = xt(d4);
    case (k)
      9:       return d8 ^ a;
      11:      return d8 ^ d2 ^ a;
      13:      return d8 ^ d4 ^ a;
      default: return d8 ^ d4 ^ d2;
    endcase
  endfunction

  function automatic col_t inv_mix_col(col_t x);
    byte_t a0 = x[31:24];
    byte_t a1 = x[23:16];
    byte_t a2 = x[15:8];
    byte_t a3 = x[7:0];
    return {mul_k(a0,14) ^ mul_k(a1,11) ^ mul_k(a2,13) ^ mul_k(a3,9),
            mul_k(a0,9)  ^ mul_k(a1,14) ^ mul_k(a2,11) ^ mul_k(a3,13),
            mul_k(a0,13) ^ mul_k(a1,9)  ^ mul_k(a2,14) ^ mul_k(a3,11),
            mul_k(a0,11) ^ mul_k(a1,13) ^ mul_k(a2,9)  ^ mul_k(a3,14)};
  endfunction
endpackage

// File: rtl/aes_key_store.sv
module aes_key_store
  import aes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  blk_t             key_in,
  input  logic             step,
  input  logic [IDX_W-1:0] rd_idx,
  output blk_t             rd_key
);
  localparam tbl_t FWD = fwd_tbl();
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ROUNDS);

  blk_t             bank [NUM_ROUNDS+1];
  logic [IDX_W-1:0] wr_ptr;
  byte_t            rcon;
  blk_t             prev, nxt;
  col_t             w0, w1, w2, w3, tw, n0, n1, n2, n3;

  assign prev = bank[wr_ptr - IDX_W'(1)];
  assign w0 = prev[127:96];
  assign w1 = prev[95:64];
  assign w2 = prev[63:32];
  assign w3 = prev[31:0];
  assign tw = {FWD[w3[23:16]] ^ rcon, FWD[w3[15:8]], FWD[w3[7:0]], FWD[w3[31:24]]};
  assign n0 = w0 ^ tw;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign nxt = {n0, n1, n2, n3};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rcon   <= 8'h01;
    end else if (load) begin
      wr_ptr <= IDX_W'(1);
      rcon   <= 8'h01;
    end else if (step) begin
      wr_ptr <= wr_ptr + IDX_W'(1);
      rcon   <= xt(rcon);
    end
  end

  always_ff @(posedge clk) begin
    if (load)      bank[0]      <= key_in;
    else if (step) bank[wr_ptr] <= nxt;
  end

  assign rd_key = bank[rd_idx];

  p_step_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (wr_ptr != '0) && (wr_ptr <= LAST));
  p_fresh_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bank[0] == $past(key_in)) && (wr_ptr == IDX_W'(1)));
endmodule

// File: rtl/aes_enc_round.sv
module aes_enc_round
  import aes_pkg::*;
(
  input  blk_t s_in,
  input  blk_t rkey,
  input  logic last,
  output blk_t s_out
);
  localparam tbl_t FWD = fwd_tbl();
  blk_t sub, shf, mix;

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_sub
    assign sub[BLK_BITS-1-8*i -: 8] = FWD[s_in[BLK_BITS-1-8*i -: 8]];
  end

  assign shf = shift_rows(sub, 1'b0);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_mix
    assign mix[BLK_BITS-1-COL_BITS*c -: COL_BITS] = mix_col(shf[BLK_BITS-1-COL_BITS*c -: COL_BITS]);
  end

  assign s_out = (last ? shf : mix) ^ rkey;
endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round
  import aes_pkg::*;
(
  input  blk_t s_in,
  input  blk_t rkey,
  input  logic last,
  output blk_t s_out
);
  localparam tbl_t INV = inv_tbl();
  blk_t shf, sub, add, mix;

  assign shf = shift_rows(s_in, 1'b1);

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_sub
    assign sub[BLK_BITS-1-8*i -: 8] = INV[shf[BLK_BITS-1-8*i -: 8]];
  end

  assign add = sub ^ rkey;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_mix
    assign mix[BLK_BITS-1-COL_BITS*c -: COL_BITS] = inv_mix_col(add[BLK_BITS-1-COL_BITS*c -: COL_BITS]);
  end

  assign s_out = last ? add : mix;
endmodule

// File: rtl/aes_core.sv
module aes_core
  import aes_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_decrypt,
  input  logic [127:0] in_key,
  input  logic [127:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ROUNDS);

  phase_t           phase;
  logic [IDX_W-1:0] cnt;
  logic             dec_q;
  blk_t             st_q;
  logic             take, step;
  logic [IDX_W-1:0] rd_idx;
  blk_t             rd_key, enc_nx, dec_nx;
  logic             last_rnd;

  assign in_ready  = (phase == PH_IDLE);
  assign out_valid = (phase == PH_OUT);
  assign out_data  = st_q;
  assign take      = in_valid && in_ready;
  assign step      = (phase == PH_EXPAND);
  assign last_rnd  = (cnt == LAST);

  always_comb begin
    if (phase == PH_WHITEN) rd_idx = dec_q ? LAST : '0;
    else                    rd_idx = dec_q ? (LAST - cnt) : cnt;
  end

  aes_key_store i_keys (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take),
    .key_in (in_key),
    .step   (step),
    .rd_idx (rd_idx),
    .rd_key (rd_key)
  );

  aes_enc_round i_enc (.s_in(st_q), .rkey(rd_key), .last(last_rnd), .s_out(enc_nx));
  aes_dec_round i_dec (.s_in(st_q), .rkey(rd_key), .last(last_rnd), .s_out(dec_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      dec_q <= 1'b0;
      st_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (in_valid) begin
          st_q  <= in_data;
          dec_q <= in_decrypt;
          cnt   <= IDX_W'(1);
          phase <= PH_EXPAND;
        end
        PH_EXPAND: begin
          if (last_rnd) phase <= PH_WHITEN;
          else          cnt   <= cnt + IDX_W'(1);
        end
        PH_WHITEN: begin
          st_q  <= st_q ^ rd_key;
          cnt   <= IDX_W'(1);
          phase <= PH_ROUND;
        end
        PH_ROUND: begin
          st_q <= dec_q ? dec_nx : enc_nx;
          if (last_rnd) phase <= PH_OUT;
          else          cnt   <= cnt + IDX_W'(1);
        end
        PH_OUT: if (out_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // cycle counter for the latency check
  logic [7:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lat_q <= '0;
    else if (take)                   lat_q <= '0;
    else if (!in_ready && !out_valid) lat_q <= lat_q + 8'd1;
  end

  p_take_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready && !out_valid);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == 8'(LATENCY));
  p_round_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ROUND) |-> (cnt != '0) && (cnt <= LAST));
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);
endmodule

// File: tb/test_aes_core.sv
module test_aes_core;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = 21;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_decrypt, out_valid, out_ready;
  logic [127:0] in_key, in_data, out_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] sb [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_core i_aes_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_decrypt(in_decrypt), .in_key(in_key), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bm(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [31:0] w [44];
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [7:0]  rc = 8'h01;
    logic [7:0]  a0, a1, a2, a3;
    logic [31:0] tmp;
    logic [127:0] o;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sb[tmp[23:16]] ^ rc, sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]};
        rc = bm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
      if (rnd < 10)
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = bm(a0,2) ^ bm(a1,3) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ bm(a1,2) ^ bm(a2,3) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ bm(a2,2) ^ bm(a3,3);
          s[4*c+3] = bm(a0,3) ^ a1 ^ a2 ^ bm(a3,2);
        end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*rnd + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  // one request through both handshakes; checks R1, R2 and R3 on the way
  task automatic run_op(input logic dec, input logic [127:0] k, input logic [127:0] d,
                        input int hold, input bit junk, output logic [127:0] res);
    int lat = 0;
    bit busy_ok = 1'b1;
    logic [127:0] snap;
    @(negedge clk);
    in_valid = 1'b1; in_decrypt = dec; in_key = k; in_data = d;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      in_decrypt = ~dec; in_key = ~k; in_data = ~d;
    end else in_valid = 1'b0;
    while (!out_valid && lat < 100) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk(busy_ok, "R1 in_ready low while busy", 128'(busy_ok), 128'd1);
    chk(lat == EXP_LAT, "R2 latency", 128'(lat), 128'(EXP_LAT));
    snap = out_data;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(out_valid && out_data == snap, "R3 hold under back-pressure", out_data, snap);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R3 release", {126'd0, in_ready, out_valid}, 128'd2);
    res = snap;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] key, pt, ct, got, got2;
    logic [7:0] inv, aff;
    for (int a = 0; a < 256; a++) begin
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (bm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        aff[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i;
      sb[a] = aff;
    end
    void'($urandom(32'h5eed_a3e5));
    rst_n = 1'b0; in_valid = 1'b0; in_decrypt = 1'b0; out_ready = 1'b0;
    in_key = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 in_ready after reset", 128'(in_ready), 128'd1);
    chk(out_valid == 1'b0, "R7 out_valid after reset", 128'(out_valid), 128'd0);

    key = 128'h000102030405060708090a0b0c0d0e0f;
    pt  = 128'h00112233445566778899aabbccddeeff;
    ct  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    chk(ref_enc(key, pt) == ct, "R4 bench model self-check", ref_enc(key, pt), ct);
    run_op(1'b0, key, pt, 3, 1'b1, got);
    chk(got == ct, "R4 known-answer encrypt", got, ct);
    run_op(1'b1, key, ct, 0, 1'b1, got);
    chk(got == pt, "R5 known-answer decrypt", got, pt);

    for (int n = 0; n < 8; n++) begin
      key = {$urandom, $urandom, $urandom, $urandom};
      pt  = {$urandom, $urandom, $urandom, $urandom};
      if (n == 0) pt = '0;
      if (n == 1) pt = '1;
      ct  = ref_enc(key, pt);
      run_op(1'b0, key, pt, int'($urandom % 4), bit'(n % 2), got);
      chk(got == ct, "R6 R8 random encrypt", got, ct);
      run_op(1'b1, key, ct, int'($urandom % 4), bit'((n + 1) % 2), got2);
      chk(got2 == pt, "R5 R6 random decrypt", got2, pt);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule